// File: doc/BRIEF.md
# Degree-Six Check Node Unit

This block does the check-node update for one parity constraint of degree six in a log-domain belief-propagation decoder. Every cycle it accepts six packed edge words. Each word carries a hard-decision bit and a sign-magnitude variable-to-check message. It returns six sign-magnitude check-to-variable messages and a syndrome bit for the constraint.

The output sign on an edge is the exclusive-or of the other five input signs. The output magnitude is a transfer-function table applied to the sum of the other five input magnitudes. The table is ln((1+e^-x)/(1-e^-x)), quantized with a step of 0.5 per magnitude unit.

The syndrome bit is the exclusive-or of the six hard decisions. It travels with the messages, so an iteration controller can test the whole code on the fly. The unit is fully pipelined with one register cut inside and registered outputs. It takes a new set of edges every cycle.

Top module: `chk_node_unit`

## Requirements
- R1: Input edge i occupies bits 6i+5 down to 6i of `chk_in`: bit 6i+5 is the hard decision, bit 6i+4 the sign (1 = negative), bits 6i+3..6i the magnitude. Output edge i occupies bits 5i+4 down to 5i of `chk_out`: bit 5i+4 is the sign, bits 5i+3..5i the magnitude.
- R2: `chk_parity` equals the XOR of the six hard-decision bits.
- R3: The output sign of edge i equals the XOR of the signs of the five other input edges.
- R4: The output magnitude of edge i is m(s), where s is the sum of the five other input magnitudes. For s > 0, m(s) = round-to-nearest(2·ln((1+e^-s/2)/(1-e^-s/2))), clipped to 15. This gives m(1)=3, m(2)=2, m(3)=1, m(4)=1 and m(s)=0 for s >= 5.
- R5: A zero exclusion sum gives the largest magnitude, 15.
- R6: Sums beyond the table range saturate. Every sum from 5 up to the maximum of 75 yields magnitude 0.
- R7: Outputs for inputs sampled at clock edge n appear after edge n+2. A new input set is accepted on every edge.
- R8: A synchronous active-high reset clears `chk_out` and `chk_parity` to zero at the next edge.
- R9: The magnitude and sign of input edge i have no effect on output edge i.
- R10: The hard-decision bits have no effect on any output message. They affect only `chk_parity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_in | input | 36 | Six packed edge words (hard bit, sign, 4-bit magnitude) |
| chk_out | output | 30 | Six packed check-to-variable messages (sign, 4-bit magnitude) |
| chk_parity | output | 1 | XOR of the six hard decisions |

## Verification
An all-zero edge set and a set with a single nonzero edge show whether each edge excludes its own contribution. The lone nonzero edge must still see the maximum magnitude while the other five shrink. All-maximum magnitudes and mid-range sums probe the saturated tail and the small-argument entries of the table. Sign patterns with one, two and six negative edges, and hard-decision patterns with fixed messages, separate the sign network from the syndrome path. A long stream of varied edge sets, applied back to back, checks the two-cycle latency and full throughput.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  // lane geometry shared by the check node unit
  localparam int CNU_EDGES = 6;
  localparam int CNU_MAG_W = 4;

  // value transported for a zero extrinsic sum (largest magnitude)
  function automatic logic [CNU_MAG_W-1:0] cnu_mag_max();
    return {CNU_MAG_W{1'b1}};
  endfunction
endpackage

// File: rtl/cnu_sign_unit.sv
module cnu_sign_unit #(
  parameter int N = 6
) (
  input  logic [N-1:0] sgn,
  input  logic [N-1:0] hd,
  output logic [N-1:0] ext_sgn,
  output logic         parity
);
  logic all_sgn;

  assign all_sgn = ^sgn;
  assign parity  = ^hd;

  // removing an edge's own sign from the full product is one more XOR
  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext_sgn[i] = all_sgn ^ sgn[i];
  end
endmodule

// File: rtl/cnu_mag_sum.sv
module cnu_mag_sum #(
  parameter int N     = 6,
  parameter int MAG_W = 4,
  parameter int SUM_W = MAG_W + $clog2(N)
) (
  input  logic [N*MAG_W-1:0] mags,
  output logic [N*SUM_W-1:0] excl
);
  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + {{(SUM_W-MAG_W){1'b0}}, mags[i*MAG_W +: MAG_W]};
    end
  end

  // one shared adder tree, then one subtractor per edge
  for (genvar i = 0; i < N; i++) begin : g_excl
    assign excl[i*SUM_W +: SUM_W] =
      total - {{(SUM_W-MAG_W){1'b0}}, mags[i*MAG_W +: MAG_W]};
  end
endmodule

// File: rtl/cnu_mag_lut.sv
module cnu_mag_lut #(
  parameter int MAG_W = 4,
  parameter int SUM_W = 7,
  parameter int IDX_W = 3
) (
  input  logic [SUM_W-1:0] sum,
  output logic [MAG_W-1:0] mag
);
  import cnu_pkg::*;

  localparam int IDX_MAX = (1 << IDX_W) - 1;

  logic [IDX_W-1:0] idx;

  // every argument above the table range yields the same tail value
  always_comb begin
    if (sum > SUM_W'(IDX_MAX)) idx = IDX_W'(IDX_MAX);
    else                       idx = sum[IDX_W-1:0];
  end

  // entries: round(2*ln(coth(s/4))) with 0.5 per unit; s=0 is infinite
  always_comb begin
    case (idx)
      IDX_W'(0): mag = cnu_mag_max();
      IDX_W'(1): mag = MAG_W'(3);
      IDX_W'(2): mag = MAG_W'(2);
      IDX_W'(3): mag = MAG_W'(1);
      IDX_W'(4): mag = MAG_W'(1);
      default:   mag = '0;
    endcase
  end
endmodule

// File: rtl/chk_node_unit.sv
module chk_node_unit #(
  parameter int N     = 6,
  parameter int MAG_W = 4,
  parameter int IDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N*(MAG_W+2)-1:0]   chk_in,
  output logic [N*(MAG_W+1)-1:0]   chk_out,
  output logic                     chk_parity
);
  localparam int IN_W  = MAG_W + 2;
  localparam int OUT_W = MAG_W + 1;
  localparam int SUM_W = MAG_W + $clog2(N);

  // ---------------- unpack ----------------
  logic [N-1:0]       in_hd;
  logic [N-1:0]       in_sgn;
  logic [N*MAG_W-1:0] in_mag;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign in_hd[i]                  = chk_in[i*IN_W + MAG_W + 1];
    assign in_sgn[i]                 = chk_in[i*IN_W + MAG_W];
    assign in_mag[i*MAG_W +: MAG_W]  = chk_in[i*IN_W +: MAG_W];
  end

  // ---------------- first half ----------------
  logic [N-1:0]       ext_sgn;
  logic               par_c;
  logic [N*SUM_W-1:0] excl_c;

  cnu_sign_unit #(.N(N)) sign_i (
    .sgn     (in_sgn),
    .hd      (in_hd),
    .ext_sgn (ext_sgn),
    .parity  (par_c)
  );

  cnu_mag_sum #(.N(N), .MAG_W(MAG_W), .SUM_W(SUM_W)) sum_i (
    .mags (in_mag),
    .excl (excl_c)
  );

  logic [N*SUM_W-1:0] s1_excl;
  logic [N-1:0]       s1_sgn;
  logic               s1_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_excl <= '0;
      s1_sgn  <= '0;
      s1_par  <= 1'b0;
    end else begin
      s1_excl <= excl_c;
      s1_sgn  <= ext_sgn;
      s1_par  <= par_c;
    end
  end

  // ---------------- second half ----------------
  logic [N*OUT_W-1:0] msg_c;

  for (genvar i = 0; i < N; i++) begin : g_lut
    logic [MAG_W-1:0] m;
    cnu_mag_lut #(.MAG_W(MAG_W), .SUM_W(SUM_W), .IDX_W(IDX_W)) lut_i (
      .sum (s1_excl[i*SUM_W +: SUM_W]),
      .mag (m)
    );
    assign msg_c[i*OUT_W +: OUT_W] = {s1_sgn[i], m};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_out    <= '0;
      chk_parity <= 1'b0;
    end else begin
      chk_out    <= msg_c;
      chk_parity <= s1_par;
    end
  end

  // ---------------- checks ----------------
  logic [1:0] fill_q;
  always_ff @(posedge clk) begin
    if (rst)                fill_q <= '0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  logic [N-1:0] out_sgn;
  for (genvar i = 0; i < N; i++) begin : g_osgn
    assign out_sgn[i] = chk_out[i*OUT_W + MAG_W];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (chk_out == '0) && !chk_parity); // R8

  AST_PARITY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd2) |-> (chk_parity == $past(^in_hd, 2))); // R2

  AST_SIGN_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd2) |-> ((^out_sgn) == $past(^in_sgn, 2))); // R3

  for (genvar i = 0; i < N; i++) begin : g_ast
    AST_ZERO_SUM_MAX: assert property (@(posedge clk) disable iff (rst)
      (s1_excl[i*SUM_W +: SUM_W] == '0) |=>
        (chk_out[i*OUT_W +: MAG_W] == {MAG_W{1'b1}})); // R5
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
      (s1_excl[i*SUM_W +: SUM_W] >= SUM_W'(5)) |=>
        (chk_out[i*OUT_W +: MAG_W] == '0)); // R6
  end
endmodule

// File: tb/chk_node_unit_tb_top.sv
module chk_node_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] chk_in = '0;
  logic [29:0] chk_out;
  logic        chk_parity;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  chk_node_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .chk_in     (chk_in),
    .chk_out    (chk_out),
    .chk_parity (chk_parity)
  );

  // scoreboard queues
  int          due_q[$];
  logic [29:0] exp_msg_q[$];
  logic        exp_par_q[$];
  string       tag_q[$];

  function automatic int mag_of(int s);
    real x, f;
    int m;
    if (s == 0) return 15;
    x = s * 0.5;
    f = $ln((1.0 + $exp(-x)) / (1.0 - $exp(-x)));
    m = $rtoi($floor(f / 0.5 + 0.5));
    if (m > 15) m = 15;
    return m;
  endfunction

  function automatic logic [29:0] model_msg(logic [35:0] v);
    logic [29:0] r;
    r = '0;
    for (int i = 0; i < 6; i++) begin
      int s;
      logic sg;
      s = 0; sg = 1'b0;
      for (int j = 0; j < 6; j++) begin
        if (j != i) begin
          s  += int'(v[6*j +: 4]);
          sg ^= v[6*j+4];
        end
      end
      r[5*i +: 5] = {sg, 4'(mag_of(s))};
    end
    return r;
  endfunction

  function automatic logic model_par(logic [35:0] v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 6; i++) p ^= v[6*i+5];
    return p;
  endfunction

  function automatic logic [35:0] lane(int i, bit hd, bit sg, int mag);
    logic [35:0] v;
    v = '0;
    v[6*i +: 6] = {hd, sg, 4'(mag)};
    return v;
  endfunction

  task automatic apply(input logic [35:0] v, input string tag);
    @(negedge clk);
    chk_in = v;
    due_q.push_back(cyc + 2);
    exp_msg_q.push_back(model_msg(v));
    exp_par_q.push_back(model_par(v));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (due_q.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (due_q.size() != 0 && due_q[0] == cyc) begin
      logic [29:0] em;
      logic        ep;
      string       tg;
      em = exp_msg_q.pop_front();
      ep = exp_par_q.pop_front();
      tg = tag_q.pop_front();
      void'(due_q.pop_front());
      checks++;
      if (chk_out !== em || chk_parity !== ep) begin
        errors++;
        $display("FAIL %s: out=%h par=%b expected out=%h par=%b",
                 tg, chk_out, chk_parity, em, ep);
      end
    end
  end

  task automatic direct_check(input string tag, input logic [29:0] em, input logic ep);
    checks++;
    if (chk_out !== em || chk_parity !== ep) begin
      errors++;
      $display("FAIL %s: out=%h par=%b expected out=%h par=%b",
               tag, chk_out, chk_parity, em, ep);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [35:0] v;
    chk_in = 36'hF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct_check("R8 reset state", '0, 1'b0);
    rst = 0;
    repeat (2) @(posedge clk);

    // R5, R9: all zero magnitudes
    apply('0, "R5 all-zero edges");
    // R9, R4: one lone nonzero edge keeps 15, others see m(1)
    apply(lane(2, 0, 0, 1), "R9 own magnitude excluded, R4 m(1)");
    apply(lane(0, 0, 0, 2) | lane(5, 0, 0, 2), "R4 sums of 2 and 4");
    apply(lane(1, 0, 0, 1) | lane(3, 0, 0, 1) | lane(4, 0, 0, 1), "R4 sums of 2 and 3");
    // R6: saturated tail
    v = '0;
    for (int i = 0; i < 6; i++) v |= lane(i, 0, 0, 15);
    apply(v, "R6 all maximum magnitudes");
    apply(lane(0, 0, 0, 5) | lane(1, 0, 0, 0), "R6 boundary sum 5");
    // R3: sign patterns
    apply(lane(3, 0, 1, 4), "R3 one negative edge, R9 own sign excluded");
    apply(lane(0, 0, 1, 1) | lane(4, 0, 1, 2), "R3 two negative edges");
    v = '0;
    for (int i = 0; i < 6; i++) v |= lane(i, 0, 1, i);
    apply(v, "R3 all negative, R1 lane order");
    // R2, R10: hard bits vary, messages fixed
    v = lane(1, 0, 1, 3) | lane(2, 0, 0, 1);
    apply(v, "R10 hard bits clear");
    for (int i = 0; i < 6; i++) v[6*i+5] = 1'b1;
    apply(v, "R10 all hard bits set, R2 even parity");
    apply(lane(4, 1, 0, 0), "R2 single hard bit");
    // R1: distinct magnitude per lane
    apply(lane(0, 1, 0, 1) | lane(5, 0, 1, 3), "R1 lane positions");
    // R7: back-to-back random stream
    for (int k = 0; k < 400; k++) apply(36'($urandom()) ^ {4'($urandom()), 32'h0}, "R7 streaming");
    drain();

    // R8: reset mid-run with live inputs
    @(negedge clk);
    rst = 1;
    chk_in = lane(0, 1, 1, 7);
    @(negedge clk);
    direct_check("R8 mid-run reset", '0, 1'b0);
    rst = 0;
    repeat (2) @(posedge clk);
    apply(lane(3, 1, 0, 2), "R7 first result after reset");
    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule